// File: doc/BRIEF.md
# Reset Source Controller with Clock Watchdog

This block gathers every reset request in a small subsystem and turns them into one system reset, `sys_rst`, timed on a free-running reference clock. There are three requesters. The first is an active-low external reset pin. The second is a supply-monitor comparator input, which can reset the system only when it is enabled and also selected as a source. The third is a watchdog on the system clock that fires when that clock stops toggling for longer than a set number of reference cycles. Pin and comparator inputs pass through a synchronizer into the reference domain. The system clock itself passes through the same kind of synchronizer, and every change of the synchronized value restarts the watchdog count.

`sys_rst` stays asserted while any source is active. After the last source drops it stays asserted for a further hold period, then releases. When it releases, a flag is latched for every source that was active during that reset. Flags left from an earlier reset are cleared as soon as a new one starts. Software reaches the block through two byte-wide registers on a plain write strobe with a combinational read. No data streams through the block, so no port uses a valid/ready handshake, and control and status pins stay plain. Register 0 is the monitor control register. Register 1 is the reset-source register: reads return the flags, and writes enable the watchdog and select the supply monitor as a reset source.

Top module: `sysrst_hub`

## Requirements
- R1: When `ext_rst_n` goes low, `sys_rst` rises exactly SYNC_STAGES+1 reference cycles later and stays high while the pin stays low.
- R2: `sys_rst` falls only after HOLD_CYC consecutive reference cycles with no active synchronized source. For the pin this is exactly SYNC_STAGES+HOLD_CYC cycles after `ext_rst_n` returns high.
- R3: Reading address 1 returns the source flags: bit 0 is the pin, bit 1 the supply monitor, bit 2 the clock watchdog, and bits 7:3 read 0. Flags are latched at release and record every source that was active during the reset. They read 0 from the start of each reset until its release.
- R4: When enabled, the watchdog issues a reset if the synchronized system clock does not change for TIMEOUT_CYC reference cycles. A clock whose level changes at least every TIMEOUT_CYC reference cycles never triggers it.
- R5: Writing address 1 with bit 2 set enables the watchdog, and writing it with bit 2 clear disables it. A disabled watchdog never resets the system, even when the clock has stopped.
- R6: Address 1 bit 1, when written, selects the supply monitor as a reset source. The supply monitor resets the system only while the monitor enable is 1, the selection is 1 and `supply_ok` is low.
- R7: At address 0, bit 7 is the monitor enable (read/write), bit 6 is the live synchronized `supply_ok` (read-only), and bit 5 is the threshold select (read/write; 1 = high). Bits 4:0 read 0 and ignore writes.
- R8: While `sys_rst` is high, register writes are ignored and the controls return to their defaults: monitor enabled, high threshold, supply monitor not selected, watchdog off.
- R9: `mon_en_o` and `thr_high_o` always show the monitor enable and the threshold select.
- R10: While `por_n` is low, `sys_rst` is high. After `por_n` rises, `sys_rst` stays high for exactly HOLD_CYC cycles, and all flags then read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Free-running reference clock; all state runs on it |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| sys_clk | input | 1 | System clock under watch, sampled as data |
| ext_rst_n | input | 1 | External reset pin, active low, input only |
| supply_ok | input | 1 | Supply comparator output, 1 = above threshold |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 monitor control, 1 reset source |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| mon_en_o | output | 1 | Supply monitor enable to the comparator |
| thr_high_o | output | 1 | Threshold select to the comparator, 1 = high |
| sys_rst | output | 1 | System reset, active high |

## Verification
On every cycle the assertions check the following. `sys_rst` follows any active source, and it releases only after a full quiet hold period. Flags stay clear for the whole of a reset. Unused register bits read zero. The monitor controls are back at their defaults while reset is held. The watchdog request never appears before the clock has been idle for the timeout. Only the bench scenarios can show the exact entry and release latencies, the boundary between a clock just fast enough and one just too slow, the effect of the supply-monitor gating combinations, the recording of several simultaneous sources, and the clearing of old flags by a new reset.

// File: rtl/sysrst_pkg.sv
package sysrst_pkg;
  localparam int SRC_N   = 3;
  localparam int SRC_PIN = 0;
  localparam int SRC_SUP = 1;
  localparam int SRC_CLK = 2;

  localparam int MC_EN_BIT   = 7;
  localparam int MC_STAT_BIT = 6;
  localparam int MC_THR_BIT  = 5;

  localparam logic ADDR_MONCTL = 1'b0;
  localparam logic ADDR_RSTSRC = 1'b1;

  typedef logic [SRC_N-1:0] src_vec_t;
endpackage

// File: rtl/sysrst_sync.sv
module sysrst_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sysrst_clk_watch.sv
module sysrst_clk_watch #(
  parameter int TIMEOUT_CYC = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic ref_clk,
  input  logic por_n,
  input  logic sys_clk,
  input  logic en,
  output logic sys_clk_s,
  output logic loss_req
);
  localparam int CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(TIMEOUT_CYC);

  logic          sc_prev;
  logic [CW-1:0] idle_q;

  sysrst_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sc_sync (
    .clk(ref_clk), .rst_n(por_n), .d(sys_clk), .q(sys_clk_s)
  );

  // One-shot: every transition of the sampled clock restarts the count.
  always_ff @(posedge ref_clk or negedge por_n) begin
    if (!por_n) begin
      sc_prev <= 1'b0;
      idle_q  <= '0;
    end else begin
      sc_prev <= sys_clk_s;
      if (!en || (sys_clk_s != sc_prev)) idle_q <= '0;
      else if (idle_q != LIM)            idle_q <= idle_q + 1'b1;
    end
  end

  assign loss_req = en && (idle_q == LIM);
endmodule

// File: rtl/sysrst_seq.sv
module sysrst_seq
  import sysrst_pkg::*;
#(
  parameter int HOLD_CYC = 16
) (
  input  logic     ref_clk,
  input  logic     por_n,
  input  src_vec_t src_now,
  output logic     sys_rst,
  output src_vec_t flags
);
  localparam int HW = $clog2(HOLD_CYC + 1);
  localparam logic [HW-1:0] LAST = HW'(HOLD_CYC - 1);

  logic          in_rst_q;
  logic [HW-1:0] hold_q;
  src_vec_t      pend_q;
  src_vec_t      flags_q;

  always_ff @(posedge ref_clk or negedge por_n) begin
    if (!por_n) begin
      in_rst_q <= 1'b1;
      hold_q   <= '0;
      pend_q   <= '0;
      flags_q  <= '0;
    end else if (!in_rst_q) begin
      if (|src_now) begin
        in_rst_q <= 1'b1;
        pend_q   <= src_now;
        flags_q  <= '0;
        hold_q   <= '0;
      end
    end else begin
      pend_q <= pend_q | src_now;
      if (|src_now) begin
        hold_q <= '0;
      end else if (hold_q == LAST) begin
        in_rst_q <= 1'b0;
        flags_q  <= pend_q;
        hold_q   <= '0;
      end else begin
        hold_q <= hold_q + 1'b1;
      end
    end
  end

  assign sys_rst = in_rst_q;
  assign flags   = flags_q;
endmodule

// File: rtl/sysrst_hub.sv
module sysrst_hub
  import sysrst_pkg::*;
#(
  parameter int TIMEOUT_CYC = 32,
  parameter int HOLD_CYC    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       ref_clk,
  input  logic       por_n,
  input  logic       sys_clk,
  input  logic       ext_rst_n,
  input  logic       supply_ok,
  input  logic       reg_wr,
  input  logic       reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       mon_en_o,
  output logic       thr_high_o,
  output logic       sys_rst
);
  logic [1:0] in_s;
  logic       pin_act;
  logic       sup_ok_s;
  logic       sys_clk_s;
  logic       loss_req;
  logic       mon_en_q, thr_high_q, sup_sel_q, det_en_q;
  src_vec_t   src_now;
  src_vec_t   flags;
  logic       unused_wbits;

  sysrst_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_in_sync (
    .clk(ref_clk), .rst_n(por_n), .d({supply_ok, ext_rst_n}), .q(in_s)
  );
  assign pin_act  = ~in_s[0];
  assign sup_ok_s = in_s[1];

  sysrst_clk_watch #(.TIMEOUT_CYC(TIMEOUT_CYC), .SYNC_STAGES(SYNC_STAGES)) u_watch (
    .ref_clk(ref_clk), .por_n(por_n), .sys_clk(sys_clk), .en(det_en_q),
    .sys_clk_s(sys_clk_s), .loss_req(loss_req)
  );

  always_comb begin
    src_now          = '0;
    src_now[SRC_PIN] = pin_act;
    src_now[SRC_SUP] = mon_en_q & sup_sel_q & ~sup_ok_s;
    src_now[SRC_CLK] = loss_req;
  end

  sysrst_seq #(.HOLD_CYC(HOLD_CYC)) u_seq (
    .ref_clk(ref_clk), .por_n(por_n), .src_now(src_now),
    .sys_rst(sys_rst), .flags(flags)
  );

  // Control fields: defaults on power-on and for as long as reset is held.
  always_ff @(posedge ref_clk or negedge por_n) begin
    if (!por_n) begin
      mon_en_q   <= 1'b1;
      thr_high_q <= 1'b1;
      sup_sel_q  <= 1'b0;
      det_en_q   <= 1'b0;
    end else if (sys_rst) begin
      mon_en_q   <= 1'b1;
      thr_high_q <= 1'b1;
      sup_sel_q  <= 1'b0;
      det_en_q   <= 1'b0;
    end else if (reg_wr) begin
      if (reg_addr == ADDR_MONCTL) begin
        mon_en_q   <= reg_wdata[MC_EN_BIT];
        thr_high_q <= reg_wdata[MC_THR_BIT];
      end else begin
        sup_sel_q <= reg_wdata[SRC_SUP];
        det_en_q  <= reg_wdata[SRC_CLK];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_MONCTL) begin
      reg_rdata[MC_EN_BIT]   = mon_en_q;
      reg_rdata[MC_STAT_BIT] = sup_ok_s;
      reg_rdata[MC_THR_BIT]  = thr_high_q;
    end else begin
      reg_rdata[SRC_N-1:0] = flags;
    end
  end

  assign unused_wbits = ^{reg_wdata[6], reg_wdata[4:3], reg_wdata[0]};
  assign mon_en_o     = mon_en_q;
  assign thr_high_o   = thr_high_q;
endmodule

// File: rtl/sysrst_hub_chk.sv
module sysrst_hub_chk
  import sysrst_pkg::*;
#(
  parameter int TIMEOUT_CYC = 32,
  parameter int HOLD_CYC    = 16
) (
  input logic       ref_clk,
  input logic       por_n,
  input src_vec_t   src_now,
  input logic       sys_rst,
  input src_vec_t   flags,
  input logic       reg_addr,
  input logic [7:0] reg_rdata,
  input logic       mon_en,
  input logic       thr_high,
  input logic       loss_req,
  input logic       sys_clk_s
);
  localparam int QW = $clog2(HOLD_CYC + 1);
  localparam int IW = $clog2(TIMEOUT_CYC + 1);

  logic [QW-1:0] quiet_q;
  logic [IW-1:0] idle_q;
  logic          sc_seen;

  always_ff @(posedge ref_clk or negedge por_n) begin
    if (!por_n) begin
      quiet_q <= '0;
      idle_q  <= '0;
      sc_seen <= 1'b0;
    end else begin
      if (!sys_rst || (|src_now)) quiet_q <= '0;
      else if (quiet_q != QW'(HOLD_CYC)) quiet_q <= quiet_q + 1'b1;
      sc_seen <= sys_clk_s;
      if (sys_clk_s != sc_seen) idle_q <= '0;
      else if (idle_q != IW'(TIMEOUT_CYC)) idle_q <= idle_q + 1'b1;
    end
  end

  a_r1_source_holds_reset: assert property (@(posedge ref_clk) disable iff (!por_n)
    (|src_now) |=> sys_rst);

  a_r2_release_after_quiet_hold: assert property (@(posedge ref_clk) disable iff (!por_n)
    $fell(sys_rst) |-> (quiet_q >= QW'(HOLD_CYC)));

  a_r3_flags_clear_in_reset: assert property (@(posedge ref_clk) disable iff (!por_n)
    sys_rst |-> (flags == '0));

  a_r3_source_reg_high_zero: assert property (@(posedge ref_clk) disable iff (!por_n)
    (reg_addr == ADDR_RSTSRC) |-> (reg_rdata[7:SRC_N] == '0));

  a_r7_monctl_low_zero: assert property (@(posedge ref_clk) disable iff (!por_n)
    (reg_addr == ADDR_MONCTL) |-> (reg_rdata[4:0] == 5'd0));

  a_r8_defaults_while_reset: assert property (@(posedge ref_clk) disable iff (!por_n)
    sys_rst |=> (mon_en && thr_high));

  a_r4_loss_only_after_timeout: assert property (@(posedge ref_clk) disable iff (!por_n)
    loss_req |-> (idle_q >= IW'(TIMEOUT_CYC)));
endmodule

bind sysrst_hub sysrst_hub_chk #(.TIMEOUT_CYC(TIMEOUT_CYC), .HOLD_CYC(HOLD_CYC)) u_chk (
  .ref_clk(ref_clk), .por_n(por_n), .src_now(src_now), .sys_rst(sys_rst),
  .flags(flags), .reg_addr(reg_addr), .reg_rdata(reg_rdata), .mon_en(mon_en_o),
  .thr_high(thr_high_o), .loss_req(loss_req), .sys_clk_s(sys_clk_s)
);

// File: tb/tb_sysrst_hub.sv
`timescale 1ns/1ps
module tb_sysrst_hub;
  localparam int T = 6;
  localparam int H = 5;
  localparam int S = 2;

  logic       ref_clk = 1'b0;
  logic       por_n = 1'b0;
  logic       sys_clk = 1'b0;
  logic       ext_rst_n = 1'b1;
  logic       supply_ok = 1'b1;
  logic       reg_wr = 1'b0;
  logic       reg_addr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       mon_en_o, thr_high_o, sys_rst;

  int checks = 0;
  int fails = 0;
  int sc_half = 1;
  int sc_cnt = 0;
  bit done = 0;

  sysrst_hub #(.TIMEOUT_CYC(T), .HOLD_CYC(H), .SYNC_STAGES(S)) dut (
    .ref_clk(ref_clk), .por_n(por_n), .sys_clk(sys_clk), .ext_rst_n(ext_rst_n),
    .supply_ok(supply_ok), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mon_en_o(mon_en_o), .thr_high_o(thr_high_o), .sys_rst(sys_rst)
  );

  always #2.5 ref_clk = ~ref_clk;

  // System clock model: toggles every sc_half reference cycles, frozen at 0.
  initial begin
    forever begin
      @(negedge ref_clk);
      if (sc_half > 0) begin
        if (sc_cnt >= sc_half - 1) begin
          sys_clk = ~sys_clk;
          sc_cnt = 0;
        end else sc_cnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge ref_clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output int v);
    reg_addr = a;
    #0.1;
    v = int'(reg_rdata);
  endtask

  task automatic watch(input int n, output bit seen);
    seen = 0;
    repeat (n) begin
      @(negedge ref_clk);
      if (sys_rst) seen = 1;
    end
  endtask

  task automatic wait_release(output int n);
    n = 0;
    while (sys_rst && n < 2000) begin
      @(negedge ref_clk);
      n++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge ref_clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int v, n;
    bit seen;
    tick(3);
    chk(sys_rst == 1'b1, "R10 reset during power-on", int'(sys_rst), 1);
    por_n = 1'b1;
    wait_release(n);
    chk(n == H, "R10 power-on hold length", n, H);
    rd(1, v); chk(v == 0, "R10 flags after power-on", v, 0);
    rd(0, v); chk(v == 8'hE0, "R8 control defaults after power-on", v, 8'hE0);
    chk(mon_en_o && thr_high_o, "R9 outputs default", int'({mon_en_o, thr_high_o}), 3);

    // Pin reset entry, flag clearing, write blocking, release timing.
    ext_rst_n = 1'b0;
    n = 0;
    while (!sys_rst && n < 50) begin @(negedge ref_clk); n++; end
    chk(n == S + 1, "R1 pin entry latency", n, S + 1);
    watch(10, seen);
    chk(sys_rst == 1'b1, "R1 held while pin low", int'(sys_rst), 1);
    rd(1, v); chk(v == 0, "R3 flags read 0 during reset", v, 0);
    wr(0, 8'h00);
    ext_rst_n = 1'b1;
    n = 0;
    while (sys_rst && n < 100) begin @(negedge ref_clk); n++; end
    chk(n == S + H, "R2 pin release latency", n, S + H);
    rd(1, v); chk(v == 1, "R3 pin flag bit 0", v, 1);
    rd(0, v); chk(v == 8'hE0, "R8 write during reset ignored", v, 8'hE0);

    // Monitor control register: every write value.
    for (int w = 0; w < 256; w++) begin
      wr(0, 8'(w));
      rd(0, v);
      chk(v == ((w & 8'hA0) | 8'h40), "R7 monitor control readback", v, (w & 8'hA0) | 8'h40);
      chk(mon_en_o == w[7] && thr_high_o == w[5], "R9 control outputs",
          int'({mon_en_o, thr_high_o}), int'({w[7], w[5]}));
    end
    wr(0, 8'hA0);
    supply_ok = 1'b0;
    watch(S + 6, seen);
    chk(!seen, "R6 unselected monitor no reset", int'(seen), 0);
    rd(0, v); chk(v == 8'hA0, "R7 live status low", v, 8'hA0);
    supply_ok = 1'b1;
    tick(S + 2);
    rd(0, v); chk(v == 8'hE0, "R7 live status high", v, 8'hE0);

    // Supply monitor gating sweep.
    for (int c = 0; c < 4; c++) begin
      bit en, sel;
      en = c[1]; sel = c[0];
      wr(0, {en, 7'h20});
      wr(1, {6'd0, sel, 1'b0});
      tick(2);
      supply_ok = 1'b0;
      watch(S + 6, seen);
      chk(seen == (en & sel), "R6 supply gating", int'(seen), int'(en & sel));
      supply_ok = 1'b1;
      if (seen) begin
        wait_release(n);
        rd(1, v); chk(v == 2, "R3 supply flag bit 1", v, 2);
        supply_ok = 1'b0;
        watch(S + 6, seen);
        chk(!seen, "R8 selection cleared by reset", int'(seen), 0);
        supply_ok = 1'b1;
      end
      tick(S + 2);
      wr(1, 8'h00);
      wr(0, 8'hA0);
    end

    // Simultaneous sources, then a new reset clears the old flags.
    wr(1, 8'h02);
    ext_rst_n = 1'b0; supply_ok = 1'b0;
    tick(8);
    ext_rst_n = 1'b1; supply_ok = 1'b1;
    wait_release(n);
    rd(1, v); chk(v == 3, "R3 both flags recorded", v, 3);
    ext_rst_n = 1'b0;
    tick(6);
    ext_rst_n = 1'b1;
    wait_release(n);
    rd(1, v); chk(v == 1, "R3 old flags cleared by new reset", v, 1);

    // Clock watchdog boundary sweep over the toggle interval.
    for (int k = 1; k <= T + 2; k++) begin
      sc_half = k;
      tick(2 * k + 4);
      wr(1, 8'h04);
      watch(4 * k + 2 * T + 8, seen);
      chk(seen == (k > T), "R4 watchdog boundary", int'(seen), int'(k > T));
      if (seen) begin
        wait_release(n);
        rd(1, v); chk(v == 4, "R3 watchdog flag bit 2", v, 4);
        watch(4 * k + 2 * T + 8, seen);
        chk(!seen, "R8 watchdog off after reset", int'(seen), 0);
      end else begin
        wr(1, 8'h00);
      end
    end

    // Stopped clock: disabled then enabled watchdog.
    sc_half = 1;
    tick(4);
    wr(1, 8'h00);
    sc_half = 0;
    watch(3 * T + 6, seen);
    chk(!seen, "R5 disabled watchdog ignores stopped clock", int'(seen), 0);
    wr(1, 8'h04);
    watch(T + S + 6, seen);
    chk(seen, "R5 enabled watchdog catches stopped clock", int'(seen), 1);
    wait_release(n);
    rd(1, v); chk(v == 4, "R4 stopped clock flag", v, 4);
    sc_half = 1;
    tick(4);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule